// File: doc/BRIEF.md
# Two-Event Classification Sequence Detector

This block watches a digitised port-voltage code during the power-up handshake of a powered device. It sorts each sample into one of six voltage windows, filters the window choice against noise, and follows the order in which the windows are visited. A source that raises the line into the classification window, drops it into the mark window, and repeats that sequence is taken to be a high-power (type-2) source. Any dip into the reset window cancels the count.

The block drives three signals. The first enables the classification current source while the classification window is held. The second raises internal bias once the line climbs past the end of the detection range. The third is an active-low indicator, pulled low only when two mark events have been recorded and the downstream converter reports that it is powered. A 2-bit mark-event count is also exposed. Samples are unsigned codes at 0.1 V per LSB.

Top module: `twoevt_cls_det`

## Requirements
- R1: `cls_src_en` is high exactly while the accepted window is the classification window (codes 130 to 205).
- R2: `bias_en` rises when a window at or above code 115 is accepted. It stays high until the reset window is accepted.
- R3: `mark_cnt` increments when the mark window (codes 54 to 97) is accepted from a higher window, but only if the classification window was accepted since the last counted mark, reset-window entry or power-window entry. A drop into the mark window with no finger before it does not count.
- R4: Accepting the reset window (codes below 54) clears `mark_cnt` to 0 and drops `bias_en`. This cancels any two-event result.
- R5: `mark_cnt` saturates at 2. Further finger and mark pairs leave it at 2.
- R6: `flag_n` is low only when `mark_cnt` equals 2 and `conv_pwr` is high. Otherwise it is high.
- R7: Every window boundary has a hysteresis of 2 codes. A sample that lies up to 2 codes outside the current window keeps that window. For example, from the classification window, code 128 and code 207 both stay in it.
- R8: A new window is accepted only after 4 consecutive valid samples select it. Cycles with `vsamp_vld` low are ignored and do not break the run. A valid sample that selects a different window restarts the run.
- R9: A two-event result survives entry into the power window (codes above 205) and any later window change above the reset window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsamp | input | CODE_W | Port-voltage sample, 0.1 V per LSB |
| vsamp_vld | input | 1 | Sample strobe |
| conv_pwr | input | 1 | Downstream converter is powered |
| cls_src_en | output | 1 | Classification current source enable |
| bias_en | output | 1 | Internal bias and regulator enable |
| mark_cnt | output | 2 | Mark events counted, saturating at 2 |
| flag_n | output | 1 | Active-low two-event indicator |

## Verification
A wrong accepted window shows up at `cls_src_en` or `bias_en` on the cycle after the fourth agreeing sample. The bench samples on exactly that cycle, and also one sample earlier. A lost or stray finger flag does not show until the next accepted mark entry, where `mark_cnt` is off by one. A bad clear shows when the reset window is accepted, where `mark_cnt` and `flag_n` keep their old values. The bench drives finger and mark patterns in several orders so that each of these errors reaches a port within one window change.

// File: rtl/twoevt_cls_det.sv
module twoevt_cls_det #(
  parameter int CODE_W  = 10,
  parameter int MARK_LO = 54,
  parameter int MARK_HI = 97,
  parameter int BIAS_ON = 115,
  parameter int CLS_LO  = 130,
  parameter int CLS_HI  = 205,
  parameter int HYST    = 2,
  parameter int AGREE   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vsamp,
  input  logic              vsamp_vld,
  input  logic              conv_pwr,
  output logic              cls_src_en,
  output logic              bias_en,
  output logic [1:0]        mark_cnt,
  output logic              flag_n
);

  localparam int CNT_W = $clog2(AGREE + 1);
  localparam int B1 = MARK_LO;
  localparam int B2 = MARK_HI + 1;
  localparam int B3 = BIAS_ON;
  localparam int B4 = CLS_LO;
  localparam int B5 = CLS_HI + 1;
  localparam int TOP = (1 << CODE_W) + HYST;

  typedef enum logic [2:0] {Z_RST, Z_MARK, Z_DET, Z_PRE, Z_CLS, Z_PWR} zone_t;

  zone_t zone, pend, cand;
  logic [CNT_W-1:0] agree_cnt;
  logic armed;
  logic commit;
  int   v;

  function automatic zone_t raw_zone(input int x);
    if (x < B1)      return Z_RST;
    else if (x < B2) return Z_MARK;
    else if (x < B3) return Z_DET;
    else if (x < B4) return Z_PRE;
    else if (x < B5) return Z_CLS;
    else             return Z_PWR;
  endfunction

  function automatic int zone_lo(input zone_t z);
    case (z)
      Z_MARK:  return B1;
      Z_DET:   return B2;
      Z_PRE:   return B3;
      Z_CLS:   return B4;
      Z_PWR:   return B5;
      default: return -HYST;
    endcase
  endfunction

  function automatic int zone_hi(input zone_t z);
    case (z)
      Z_RST:   return B1 - 1;
      Z_MARK:  return B2 - 1;
      Z_DET:   return B3 - 1;
      Z_PRE:   return B4 - 1;
      Z_CLS:   return B5 - 1;
      default: return TOP;
    endcase
  endfunction

  assign v = int'(vsamp);

  always_comb begin
    if (v >= zone_lo(zone) - HYST && v <= zone_hi(zone) + HYST) cand = zone;
    else cand = raw_zone(v);
  end

  assign commit = vsamp_vld && (cand != zone) && (cand == pend) &&
                  (agree_cnt == CNT_W'(AGREE - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      zone      <= Z_RST;
      pend      <= Z_RST;
      agree_cnt <= '0;
    end else if (vsamp_vld) begin
      if (cand == zone) begin
        agree_cnt <= '0;
      end else if (commit) begin
        zone      <= cand;
        agree_cnt <= '0;
      end else if (cand == pend) begin
        agree_cnt <= agree_cnt + 1'b1;
      end else begin
        pend      <= cand;
        agree_cnt <= CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bias_en  <= 1'b0;
      mark_cnt <= 2'd0;
      armed    <= 1'b0;
    end else if (commit) begin
      case (cand)
        Z_RST: begin
          bias_en  <= 1'b0;
          mark_cnt <= 2'd0;
          armed    <= 1'b0;
        end
        Z_MARK: begin
          if (armed && zone > Z_MARK) begin
            armed <= 1'b0;
            if (mark_cnt != 2'd2) mark_cnt <= mark_cnt + 2'd1;
          end
        end
        Z_PRE: bias_en <= 1'b1;
        Z_CLS: begin
          bias_en <= 1'b1;
          armed   <= 1'b1;
        end
        Z_PWR: begin
          bias_en <= 1'b1;
          armed   <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign cls_src_en = (zone == Z_CLS);
  assign flag_n     = !((mark_cnt == 2'd2) && conv_pwr);

  // R8: window changes only on a valid sample
  a_r8_change_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (zone != $past(zone)) |-> $past(vsamp_vld));

  // R5: count never exceeds 2
  a_r5_sat: assert property (@(posedge clk) disable iff (!rst_n)
    mark_cnt <= 2'd2);

  // R3 / R4: count moves by +1 or clears
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_cnt != $past(mark_cnt)) |-> (mark_cnt == 2'd0 || mark_cnt == $past(mark_cnt) + 2'd1));

  // R2: source enable implies bias
  a_r2_bias_with_cls: assert property (@(posedge clk) disable iff (!rst_n)
    cls_src_en |-> bias_en);

  // R4: reset window holds nothing
  a_r4_rst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (zone == Z_RST) |-> (mark_cnt == 2'd0 && !bias_en));

  // R6: indicator only with powered converter
  a_r6_flag_pwr: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_n |-> conv_pwr);

endmodule

// File: tb/sim_twoevt_cls_det.sv
module sim_twoevt_cls_det;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [9:0] vsamp = '0;
  logic       vsamp_vld = 0;
  logic       conv_pwr = 0;
  logic       cls_src_en, bias_en, flag_n;
  logic [1:0] mark_cnt;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  twoevt_cls_det u0 (
    .clk(clk), .rst_n(rst_n), .vsamp(vsamp), .vsamp_vld(vsamp_vld),
    .conv_pwr(conv_pwr), .cls_src_en(cls_src_en), .bias_en(bias_en),
    .mark_cnt(mark_cnt), .flag_n(flag_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vsamp = 10'(code);
      vsamp_vld = 1;
    end
    @(negedge clk);
    vsamp_vld = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset cls", cls_src_en, 0);
    chk("R2 reset bias", bias_en, 0);
    chk("R3 reset cnt", mark_cnt, 0);
    chk("R6 reset flag", flag_n, 1);
  endtask

  task automatic t_single;
    step(100, 6); chk("R2 bias low in detect", bias_en, 0);
    step(120, 6); chk("R2 bias up at 115+", bias_en, 1);
    chk("R1 cls off below window", cls_src_en, 0);
    step(150, 6); chk("R1 cls on in window", cls_src_en, 1);
    step(80, 6);  chk("R1 cls off in mark", cls_src_en, 0);
    chk("R3 one mark", mark_cnt, 1);
    chk("R2 bias held in mark", bias_en, 1);
    conv_pwr = 1;
    step(250, 6); chk("R6 single event flag", flag_n, 1);
    chk("R9 count held in power", mark_cnt, 1);
    step(30, 6);  chk("R4 cnt cleared", mark_cnt, 0);
    chk("R4 bias cleared", bias_en, 0);
    conv_pwr = 0;
  endtask

  task automatic t_two;
    step(150, 6); step(80, 6); step(150, 6); step(80, 6);
    chk("R3 two marks", mark_cnt, 2);
    step(250, 6); chk("R6 flag needs conv_pwr", flag_n, 1);
    conv_pwr = 1;
    @(negedge clk); chk("R6 flag low", flag_n, 0);
    chk("R1 cls off in power", cls_src_en, 0);
    step(150, 6); step(80, 6);
    chk("R5 saturate", mark_cnt, 2);
    step(120, 6); chk("R9 held above reset", flag_n, 0);
    step(30, 6);  chk("R4 cnt cleared after two", mark_cnt, 0);
    chk("R6 flag released by reset", flag_n, 1);
    conv_pwr = 0;
  endtask

  task automatic t_dip;
    step(150, 6); step(80, 6); step(30, 6); step(150, 6); step(80, 6);
    chk("R4 dip cancels first event", mark_cnt, 1);
    step(30, 6);
  endtask

  task automatic t_nofinger;
    step(120, 6); step(80, 6);
    chk("R3 mark without finger", mark_cnt, 0);
    step(120, 6); step(80, 6);
    chk("R3 repeated mark without finger", mark_cnt, 0);
    step(30, 6);
  endtask

  task automatic t_hyst;
    step(150, 6);
    step(128, 6); chk("R7 low edge keeps cls", cls_src_en, 1);
    step(127, 6); chk("R7 beyond low edge", cls_src_en, 0);
    step(150, 6);
    step(207, 6); chk("R7 high edge keeps cls", cls_src_en, 1);
    step(208, 6); chk("R7 beyond high edge", cls_src_en, 0);
    step(30, 6);
  endtask

  task automatic t_filter;
    step(120, 6);
    step(150, 3); chk("R8 three samples not enough", cls_src_en, 0);
    repeat (5) @(negedge clk);
    chk("R8 invalid gap ignored", cls_src_en, 0);
    step(150, 1); chk("R8 fourth valid commits", cls_src_en, 1);
    step(120, 6); chk("R8 back to pre", cls_src_en, 0);
    step(150, 3); step(120, 1); step(150, 3);
    chk("R8 interrupted run", cls_src_en, 0);
    step(150, 1); chk("R8 run completes", cls_src_en, 1);
    step(30, 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_two();
    t_dip();
    t_nofinger();
    t_hyst();
    t_filter();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule